// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches over software by counting toward a timeout and raising a one-cycle reset request if software lets the count run out. The count advances either on a slow periodic tick or on every bus clock cycle. Six timeout lengths are available, three per source, and a window option restricts when servicing is accepted. The window option works only when the bus clock is the source. Software services the watchdog by writing two key bytes in order.

The configuration is taken from a control write port that locks after its first write following reset. Later writes are dropped. This means a program that has gone astray cannot loosen the watchdog. Debug, stop and deep low-power status inputs decide whether the count holds, clears or is switched off altogether. The reset controller and the tick generator sit outside the block.

Timeout exponents are parameters: `SLOW_EXP1..3` (defaults 5, 8, 10) for the tick source and `BUS_EXP1..3` (defaults 13, 16, 18) for the bus source. A timeout of exponent E means 2^E counted events.

Top module: `winwdt_top`

## Requirements
- R1: With the tick source (`cfg_src`=0), select values 2'b01, 2'b10 and 2'b11 time out after 2^SLOW_EXP1, 2^SLOW_EXP2 and 2^SLOW_EXP3 ticks. Counting starts from the configuring write.
- R2: After reset, and before any configuration write, the block runs with the tick source, select 2'b11 and the window off.
- R3: With the bus source (`cfg_src`=1), select values 2'b01, 2'b10 and 2'b11 time out after 2^BUS_EXP1, 2^BUS_EXP2 and 2^BUS_EXP3 bus cycles.
- R4: Select 2'b00 disables the watchdog. The count stays at zero and no request is ever raised.
- R5: `rst_req` is high for exactly one cycle, in the cycle after the edge that brings the count to the timeout. The count then restarts from zero, so the next request follows one full timeout later.
- R6: Only the first `cfg_wr` after reset is accepted, and it clears the count. Later configuration writes change neither the settings nor the count.
- R7: A service write of 8'h55 followed directly by a service write of 8'hAA clears the count on the 8'hAA edge. Any other value, or the reverse order, leaves the count running.
- R8: With the bus source and `cfg_win`=1, the window opens at three quarters of the timeout. A service write of any value made while the count is below that point raises `rst_req` in the next cycle. A key pair written at or after that point clears the count.
- R9: `cfg_win` has no effect with the tick source, so early servicing is accepted there.
- R10: With the bus source, the count holds while `dbg_mode` or `stop_mode` is high and resumes from the held value afterwards.
- R11: With the tick source, the count is forced to zero while `dbg_mode` or `stop_mode` is high and counts up from zero after both fall.
- R12: While `deep_lp` is high the count is held at zero and no request is raised. After it falls, a full timeout is needed.
- R13: With the tick source, the count advances only on edges where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow tick, one-cycle enable per tick |
| svc_wr | input | 1 | Service write strobe |
| svc_data | input | 8 | Service write data |
| dbg_mode | input | 1 | Debug mode status |
| stop_mode | input | 1 | Stop mode status |
| deep_lp | input | 1 | Deep low-power mode status |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | 1 | Clock source: 0 tick, 1 bus |
| cfg_tsel | input | 2 | Timeout select, 2'b00 off |
| cfg_win | input | 1 | Window mode enable |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench sweeps every source and select pair with small exponents. It measures the exact edge of each request, so an off-by-one terminal compare or an exponent table that is swapped shows up as a wrong cycle count. The window edge is probed one count below and at the opening point. A design that compares with the wrong relation would reset a legal write or accept an early one. Debug and stop are applied in both source modes. A design that clears instead of holding on the bus clock, or holds instead of clearing on the tick, gives a timeout that is shifted by the halted span. Further runs cover a second configuration write, key pairs in the wrong order or broken by a stray value, and a deep low-power span longer than the timeout. Each of these catches a lock that leaks, a sequence detector that is too lax, or a request that leaks out while the block is powered down.

// File: rtl/winwdt_pkg.sv
`timescale 1ns/1ps
package winwdt_pkg;

    typedef enum logic {
        SRC_TICK = 1'b0,
        SRC_BUS  = 1'b1
    } clk_src_e;

    typedef struct packed {
        clk_src_e   src;
        logic [1:0] tsel;
        logic       win;
    } wd_cfg_t;

    localparam wd_cfg_t CFG_DEFAULT = '{src: SRC_TICK, tsel: 2'b11, win: 1'b0};

    localparam logic [7:0] SVC_KEY_A = 8'h55;
    localparam logic [7:0] SVC_KEY_B = 8'hAA;

    // Exponent chosen by a timeout select; zero means switched off.
    function automatic int unsigned pick_exp(input logic [1:0] sel,
                                             input int unsigned e1,
                                             input int unsigned e2,
                                             input int unsigned e3);
        case (sel)
            2'b01:   return e1;
            2'b10:   return e2;
            2'b11:   return e3;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned max_of3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/winwdt_cfg_lock.sv
`timescale 1ns/1ps
module winwdt_cfg_lock
    import winwdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cfg_wr,
    input  wd_cfg_t cfg_in,
    output wd_cfg_t cfg_q,
    output logic    locked,
    output logic    load
);

    // A write is accepted only while the register is still open.
    assign load = cfg_wr && !locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_DEFAULT;
            locked <= 1'b0;
        end else if (load) begin
            cfg_q  <= cfg_in;
            locked <= 1'b1;
        end
    end

endmodule

// File: rtl/winwdt_svc_seq.sv
`timescale 1ns/1ps
module winwdt_svc_seq
    import winwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       svc_done
);

    logic armed;

    // Second key completes the pair only if the previous write was the first key.
    assign svc_done = svc_wr && armed && (svc_data == SVC_KEY_B);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            armed <= 1'b0;
        end else if (svc_wr) begin
            armed <= (svc_data == SVC_KEY_A);
        end
    end

endmodule

// File: rtl/winwdt_limits.sv
`timescale 1ns/1ps
module winwdt_limits
    import winwdt_pkg::*;
#(
    parameter int unsigned SLOW_EXP1 = 5,
    parameter int unsigned SLOW_EXP2 = 8,
    parameter int unsigned SLOW_EXP3 = 10,
    parameter int unsigned BUS_EXP1  = 13,
    parameter int unsigned BUS_EXP2  = 16,
    parameter int unsigned BUS_EXP3  = 18,
    parameter int unsigned CNT_W     = 18
)(
    input  wd_cfg_t          cfg,
    output logic [CNT_W-1:0] term_m1,
    output logic [CNT_W-1:0] win_open,
    output logic             win_active
);

    int unsigned      exp_sel;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   quarter;
    logic [CNT_W:0]   span_m1;
    logic [CNT_W:0]   open_w;

    always_comb begin
        if (cfg.src == SRC_BUS) begin
            exp_sel = pick_exp(cfg.tsel, BUS_EXP1, BUS_EXP2, BUS_EXP3);
        end else begin
            exp_sel = pick_exp(cfg.tsel, SLOW_EXP1, SLOW_EXP2, SLOW_EXP3);
        end
        span    = (CNT_W+1)'(1) << exp_sel;
        quarter = span >> 2;
        span_m1 = span - (CNT_W+1)'(1);
        open_w  = span - quarter;
        term_m1  = span_m1[CNT_W-1:0];
        win_open = open_w[CNT_W-1:0];
    end

    // Windowing is honoured only on the bus clock.
    assign win_active = cfg.win && (cfg.src == SRC_BUS);

endmodule

// File: rtl/winwdt_counter.sv
`timescale 1ns/1ps
module winwdt_counter #(
    parameter int unsigned CNT_W = 18
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             zero_force,
    input  logic             run_en,
    input  logic [CNT_W-1:0] term_m1,
    input  logic [CNT_W-1:0] win_open,
    input  logic             win_active,
    input  logic             svc_any,
    input  logic             svc_done,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req
);

    logic early_hit;

    assign early_hit = win_active && svc_any && (cnt < win_open);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (clr || zero_force) begin
                cnt <= '0;
            end else if (early_hit) begin
                cnt     <= '0;
                rst_req <= 1'b1;
            end else if (svc_done) begin
                cnt <= '0;
            end else if (run_en) begin
                if (cnt == term_m1) begin
                    cnt     <= '0;
                    rst_req <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/winwdt_top.sv
`timescale 1ns/1ps
module winwdt_top
    import winwdt_pkg::*;
#(
    parameter int unsigned SLOW_EXP1 = 5,
    parameter int unsigned SLOW_EXP2 = 8,
    parameter int unsigned SLOW_EXP3 = 10,
    parameter int unsigned BUS_EXP1  = 13,
    parameter int unsigned BUS_EXP2  = 16,
    parameter int unsigned BUS_EXP3  = 18
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    input  logic       dbg_mode,
    input  logic       stop_mode,
    input  logic       deep_lp,
    input  logic       cfg_wr,
    input  logic       cfg_src,
    input  logic [1:0] cfg_tsel,
    input  logic       cfg_win,
    output logic       rst_req
);

    localparam int unsigned CNT_W = max_of3(max_of3(SLOW_EXP1, SLOW_EXP2, SLOW_EXP3),
                                            max_of3(BUS_EXP1, BUS_EXP2, BUS_EXP3), 2);

    wd_cfg_t          cfg_in;
    wd_cfg_t          cfg_q;
    logic             locked;
    logic             load;
    logic [CNT_W-1:0] term_m1;
    logic [CNT_W-1:0] win_open;
    logic             win_active;
    logic [CNT_W-1:0] cnt_q;
    logic             svc_done;
    logic             halted;
    logic             active;
    logic             zero_force;
    logic             run_en;
    logic             flush;

    assign cfg_in = '{src: clk_src_e'(cfg_src), tsel: cfg_tsel, win: cfg_win};

    winwdt_cfg_lock u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_wr (cfg_wr),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .locked (locked),
        .load   (load)
    );

    winwdt_limits #(
        .SLOW_EXP1 (SLOW_EXP1),
        .SLOW_EXP2 (SLOW_EXP2),
        .SLOW_EXP3 (SLOW_EXP3),
        .BUS_EXP1  (BUS_EXP1),
        .BUS_EXP2  (BUS_EXP2),
        .BUS_EXP3  (BUS_EXP3),
        .CNT_W     (CNT_W)
    ) u_lim (
        .cfg        (cfg_q),
        .term_m1    (term_m1),
        .win_open   (win_open),
        .win_active (win_active)
    );

    // Run control: switched off, cleared on tick-source halt, held on bus-source halt.
    assign halted     = dbg_mode || stop_mode;
    assign active     = (cfg_q.tsel != 2'b00) && !deep_lp;
    assign zero_force = !active || ((cfg_q.src == SRC_TICK) && halted);
    assign run_en     = (cfg_q.src == SRC_BUS) ? !halted : tick_en;
    assign flush      = rst_req || load || zero_force;

    winwdt_svc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .svc_wr   (svc_wr),
        .svc_data (svc_data),
        .svc_done (svc_done)
    );

    winwdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .clr        (load),
        .zero_force (zero_force),
        .run_en     (run_en),
        .term_m1    (term_m1),
        .win_open   (win_open),
        .win_active (win_active),
        .svc_any    (svc_wr),
        .svc_done   (svc_done),
        .cnt        (cnt_q),
        .rst_req    (rst_req)
    );

endmodule

// File: rtl/winwdt_chk.sv
`timescale 1ns/1ps
module winwdt_chk
    import winwdt_pkg::*;
#(
    parameter int unsigned CNT_W = 18
)(
    input logic             clk,
    input logic             rst,
    input logic             rst_req,
    input logic             deep_lp,
    input logic             dbg_mode,
    input logic             stop_mode,
    input logic             svc_wr,
    input logic             locked,
    input wd_cfg_t          cfg_q,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] win_open
);

    logic win_on;
    assign win_on = cfg_q.win && (cfg_q.src == SRC_BUS) && (cfg_q.tsel != 2'b00);

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && $stable(cfg_q)));

    // R4
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.tsel == 2'b00) |-> (cnt == '0 && !rst_req));

    // R12
    lowpower_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        deep_lp |=> (!rst_req && cnt == '0));

    // R11
    tick_halt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.src == SRC_TICK) && (dbg_mode || stop_mode)) |=> (cnt == '0));

    // R10
    bus_halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.src == SRC_BUS) && (dbg_mode || stop_mode) && !svc_wr && !deep_lp
         && (cfg_q.tsel != 2'b00)) |=> $stable(cnt));

    // R8
    early_svc_chk: assert property (@(posedge clk) disable iff (rst)
        (win_on && !deep_lp && svc_wr && (cnt < win_open)) |=> rst_req);

endmodule

bind winwdt_top winwdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rst_req   (rst_req),
    .deep_lp   (deep_lp),
    .dbg_mode  (dbg_mode),
    .stop_mode (stop_mode),
    .svc_wr    (svc_wr),
    .locked    (locked),
    .cfg_q     (cfg_q),
    .cnt       (cnt_q),
    .win_open  (win_open)
);

// File: tb/test_winwdt_top.sv
`timescale 1ns/1ps
module test_winwdt_top;

    localparam int unsigned SE1 = 3, SE2 = 4, SE3 = 5;
    localparam int unsigned BE1 = 4, BE2 = 5, BE3 = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       dbg_mode = 1'b0;
    logic       stop_mode = 1'b0;
    logic       deep_lp = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_src = 1'b0;
    logic [1:0] cfg_tsel = 2'b00;
    logic       cfg_win = 1'b0;
    logic       rst_req;

    int  checks = 0;
    int  errors = 0;
    bit  tick_alt = 1'b0;

    always #2 clk = ~clk;

    winwdt_top #(
        .SLOW_EXP1 (SE1), .SLOW_EXP2 (SE2), .SLOW_EXP3 (SE3),
        .BUS_EXP1  (BE1), .BUS_EXP2  (BE2), .BUS_EXP3  (BE3)
    ) i_winwdt_top (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .svc_wr    (svc_wr),
        .svc_data  (svc_data),
        .dbg_mode  (dbg_mode),
        .stop_mode (stop_mode),
        .deep_lp   (deep_lp),
        .cfg_wr    (cfg_wr),
        .cfg_src   (cfg_src),
        .cfg_tsel  (cfg_tsel),
        .cfg_win   (cfg_win),
        .rst_req   (rst_req)
    );

    function automatic int span(input int unsigned e);
        return 1 << e;
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
        if (tick_alt) tick_en = ~tick_en;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        tick_alt  = 1'b0;
        tick_en   = 1'b1;
        svc_wr    = 1'b0;
        svc_data  = 8'h00;
        dbg_mode  = 1'b0;
        stop_mode = 1'b0;
        deep_lp   = 1'b0;
        cfg_wr    = 1'b0;
        rst       = 1'b1;
        cyc();
        cyc();
        rst = 1'b0;
    endtask

    task automatic configure(input logic src, input logic [1:0] tsel, input logic win);
        cfg_src  = src;
        cfg_tsel = tsel;
        cfg_win  = win;
        cfg_wr   = 1'b1;
        cyc();
        cfg_wr   = 1'b0;
    endtask

    task automatic wait_req(input int maxc, output int n);
        n = 0;
        for (int i = 1; i <= maxc; i++) begin
            cyc();
            if (rst_req) begin
                n = i;
                return;
            end
        end
    endtask

    task automatic idle(input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            cyc();
            if (rst_req) seen = 1'b1;
        end
    endtask

    task automatic service(input logic [7:0] v);
        svc_wr   = 1'b1;
        svc_data = v;
        cyc();
        svc_wr   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int  n;
        bit  seen;

        // R2: reset state and default timeout
        do_reset();
        check(rst_req == 1'b0, "R2 reset", int'(rst_req), 0);
        wait_req(200, n);
        check(n == span(SE3), "R2 default timeout", n, span(SE3));

        // R1: tick source sweep; R3: bus source sweep; R5: back-to-back
        for (int s = 1; s <= 3; s++) begin
            int e;
            e = (s == 1) ? SE1 : (s == 2) ? SE2 : SE3;
            do_reset();
            configure(1'b0, 2'(s), 1'b0);
            wait_req(300, n);
            check(n == span(e), "R1 tick timeout", n, span(e));
        end
        for (int s = 1; s <= 3; s++) begin
            int e;
            e = (s == 1) ? BE1 : (s == 2) ? BE2 : BE3;
            do_reset();
            configure(1'b1, 2'(s), 1'b0);
            wait_req(300, n);
            check(n == span(e), "R3 bus timeout", n, span(e));
            wait_req(300, n);
            check(n == span(e), "R5 restart after request", n, span(e));
        end

        // R13: tick every other cycle
        do_reset();
        configure(1'b0, 2'b01, 1'b0);
        tick_en  = 1'b0;
        tick_alt = 1'b1;
        wait_req(300, n);
        check(n == 2 * span(SE1), "R13 sparse ticks", n, 2 * span(SE1));
        tick_alt = 1'b0;
        tick_en  = 1'b1;

        // R4: disabled on both sources
        for (int src = 0; src < 2; src++) begin
            do_reset();
            configure(1'(src), 2'b00, 1'b0);
            idle(300, seen);
            check(!seen, "R4 disabled", int'(seen), 0);
        end

        // R6: configuring write clears the count; later write ignored
        do_reset();
        idle(10, seen);
        configure(1'b1, 2'b01, 1'b0);
        wait_req(300, n);
        check(n == span(BE1), "R6 write clears count", n, span(BE1));
        do_reset();
        configure(1'b1, 2'b01, 1'b0);
        idle(5, seen);
        configure(1'b0, 2'b11, 1'b1);
        wait_req(300, n);
        check(n == span(BE1) - 6, "R6 second write ignored", n, span(BE1) - 6);

        // R7: correct pair, reversed pair, broken pair
        do_reset();
        configure(1'b1, 2'b10, 1'b0);
        idle(10, seen);
        service(8'h55);
        service(8'hAA);
        wait_req(300, n);
        check(n == span(BE2), "R7 key pair clears", n, span(BE2));
        do_reset();
        configure(1'b1, 2'b10, 1'b0);
        idle(10, seen);
        service(8'hAA);
        service(8'h55);
        wait_req(300, n);
        check(n == span(BE2) - 12, "R7 reversed pair", n, span(BE2) - 12);
        do_reset();
        configure(1'b1, 2'b10, 1'b0);
        idle(10, seen);
        service(8'h55);
        service(8'h12);
        service(8'hAA);
        wait_req(300, n);
        check(n == span(BE2) - 13, "R7 broken pair", n, span(BE2) - 13);

        // R8: window boundary, open point is 3/4 of the timeout
        do_reset();
        configure(1'b1, 2'b11, 1'b1);
        idle(10, seen);
        service(8'h55);
        check(rst_req == 1'b1, "R8 early first key", int'(rst_req), 1);
        cyc();
        check(rst_req == 1'b0, "R5 early request one cycle", int'(rst_req), 0);
        do_reset();
        configure(1'b1, 2'b11, 1'b1);
        idle(3 * span(BE3) / 4 - 1, seen);
        service(8'hAA);
        check(rst_req == 1'b1, "R8 one below window", int'(rst_req), 1);
        do_reset();
        configure(1'b1, 2'b11, 1'b1);
        idle(3 * span(BE3) / 4, seen);
        service(8'h55);
        check(rst_req == 1'b0, "R8 write at window", int'(rst_req), 0);
        service(8'hAA);
        check(rst_req == 1'b0, "R8 pair in window", int'(rst_req), 0);
        wait_req(300, n);
        check(n == span(BE3), "R8 pair in window clears", n, span(BE3));

        // R9: window bit ignored with tick source
        do_reset();
        configure(1'b0, 2'b10, 1'b1);
        idle(3, seen);
        service(8'h55);
        service(8'hAA);
        check(rst_req == 1'b0, "R9 early service tick", int'(rst_req), 0);
        wait_req(300, n);
        check(n == span(SE2), "R9 early service clears", n, span(SE2));

        // R10: bus source holds during debug and stop
        do_reset();
        configure(1'b1, 2'b01, 1'b0);
        idle(5, seen);
        dbg_mode = 1'b1;
        idle(10, seen);
        dbg_mode = 1'b0;
        check(!seen, "R10 no request in debug", int'(seen), 0);
        wait_req(300, n);
        check(n == span(BE1) - 5, "R10 debug hold", n, span(BE1) - 5);
        do_reset();
        configure(1'b1, 2'b01, 1'b0);
        idle(5, seen);
        stop_mode = 1'b1;
        idle(30, seen);
        stop_mode = 1'b0;
        wait_req(300, n);
        check(n == span(BE1) - 5, "R10 stop hold", n, span(BE1) - 5);

        // R11: tick source clears during stop and debug
        do_reset();
        configure(1'b0, 2'b10, 1'b0);
        idle(5, seen);
        stop_mode = 1'b1;
        idle(3, seen);
        stop_mode = 1'b0;
        wait_req(300, n);
        check(n == span(SE2), "R11 stop clears", n, span(SE2));
        do_reset();
        configure(1'b0, 2'b10, 1'b0);
        idle(12, seen);
        dbg_mode = 1'b1;
        cyc();
        dbg_mode = 1'b0;
        wait_req(300, n);
        check(n == span(SE2), "R11 debug clears", n, span(SE2));

        // R12: deep low-power
        do_reset();
        configure(1'b1, 2'b01, 1'b0);
        idle(5, seen);
        deep_lp = 1'b1;
        idle(40, seen);
        deep_lp = 1'b0;
        check(!seen, "R12 quiet in low power", int'(seen), 0);
        wait_req(300, n);
        check(n == span(BE1), "R12 restart from zero", n, span(BE1));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule